// File: doc/BRIEF.md
# Multi-Waveform Audio Tone Generator

This block turns a system clock into an audible tone of a chosen frequency in hertz. A two-bit select picks one of three shapes. The square shape is a single logic-level pin. The triangle and sine shapes come out as an 8-bit sample word that an external resistor-ladder converter turns into a voltage. An enable starts the tone and stops it. Each time the enable is raised, the tone starts again from its initial phase.

A single reloading down-counter sets the pace for every shape. Its reload value comes from the clock rate, the requested frequency and the number of steps per period of the selected shape. The square shape toggles on each counter expiry. The triangle moves one code up or down per expiry. The sine shape advances the read address of a 629-entry table. The table has a registered read port, so the sample for an address appears one clock after that address.

Top module: `tone_gen`

## Requirements
- R1: `wave_i` selects the shape: 0 is square, 1 is triangle, 2 is sine. Code 3 is silent: `square_o` is 0 and `sample_o` is 128.
- R2: In square mode, `square_o` goes high on the first enabled clock edge and then toggles every N = floor(CLK_HZ / (2·f)) clocks. Meanwhile `sample_o` stays at 128.
- R3: In triangle mode, `sample_o` starts at 0 and moves by one every N = floor(CLK_HZ / (510·f)) clocks. It rises to 255, then falls back to 0 and repeats, giving 510 steps per period. The first step happens on the first enabled edge.
- R4: Sine table entry k (0 to 628) equals round(128 + 127·sin(k/100)). Entries 0 and 628 are both 128, and entry 157 is 255.
- R5: In sine mode, the table address starts at 0 and advances by one every N = floor(CLK_HZ / (629·f)) clocks, wrapping from 628 to 0. `sample_o` shows the entry for the address held one clock earlier.
- R6: One divider serves all shapes. It reloads with N−1 on each expiry. A frequency of 0 is treated as 1, and N is never less than 1.
- R7: While `en_i` is low, `square_o` is 0 and `sample_o` is 128 in the same cycle. All phase state returns to its start, so the next enable begins the tone afresh.
- R8: A synchronous reset clears the divider, the square level and the table address, and sets the triangle to 0 with rising direction.
- R9: `square_o` is 0 whenever the select is not square. The state of an unselected shape does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (CLK_HZ, default 25 MHz) |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Tone enable |
| wave_i | input | 2 | Shape select (0 square, 1 triangle, 2 sine) |
| freq_i | input | FREQ_W | Tone frequency in hertz |
| square_o | output | 1 | Square-wave pin |
| sample_o | output | SAMPLE_W | Sample word for the converter |

## Verification
A wrong divider count shows at the ports within one reload interval: a square edge, a triangle step or a sine sample arrives a cycle early or late. A bad triangle direction flag shows at the first turn-around, when the output goes to 0 instead of 254. A bad address wrap shows 629 steps after the sine starts, when the output jumps to a wrong level instead of retracing 128, 129, and so on. A read-port latency fault shifts every sine sample by a clock, and the per-cycle comparison catches it on the first step.

// File: rtl/tone_pkg.sv
package tone_pkg;

  typedef enum logic [1:0] {
    WAVE_SQUARE = 2'd0,
    WAVE_TRI    = 2'd1,
    WAVE_SINE   = 2'd2,
    WAVE_OFF    = 2'd3
  } wave_e;

  // clocks per step: clk_hz / (f * steps), f of 0 counts as 1, never below 1
  function automatic int unsigned calc_interval(int unsigned clk_hz,
                                                int unsigned f,
                                                int unsigned steps);
    int unsigned f_eff;
    int unsigned q;
    f_eff = (f == 0) ? 1 : f;
    q = clk_hz / (f_eff * steps);
    return (q == 0) ? 1 : q;
  endfunction

  // table entry k = round(mid + (mid-1) * sin(k/100))
  function automatic int sine_entry(int k, int mid);
    real v;
    v = real'(mid) + real'(mid - 1) * $sin(real'(k) / 100.0) + 0.5;
    return $rtoi(v);
  endfunction

endpackage

// File: rtl/tone_rate.sv
module tone_rate #(
  parameter int CLK_HZ    = 25_000_000,
  parameter int FREQ_W    = 10,
  parameter int CNT_W     = 24,
  parameter int TRI_STEPS = 510,
  parameter int SIN_STEPS = 629
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [1:0]        wave,
  input  logic [FREQ_W-1:0] freq,
  output logic              tick,
  output logic [CNT_W-1:0]  interval,
  output logic [CNT_W-1:0]  cnt
);
  import tone_pkg::*;

  int unsigned steps;

  always_comb begin
    case (wave_e'(wave))
      WAVE_TRI:  steps = TRI_STEPS;
      WAVE_SINE: steps = SIN_STEPS;
      default:   steps = 2;
    endcase
  end

  assign interval = CNT_W'(calc_interval(CLK_HZ, int'(freq), steps));
  assign tick     = en && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || !en)  cnt <= '0;
    else if (tick)   cnt <= interval - 1'b1;
    else             cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/tone_tri.sv
module tone_tri #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         step,
  output logic [W-1:0] val,
  output logic         up
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      val <= '0;
      up  <= 1'b1;
    end else if (step) begin
      if (up) begin
        if (val == TOP) begin
          up  <= 1'b0;
          val <= TOP - 1'b1;
        end else begin
          val <= val + 1'b1;
        end
      end else begin
        if (val == '0) begin
          up  <= 1'b1;
          val <= W'(1);
        end else begin
          val <= val - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tone_sine.sv
module tone_sine #(
  parameter int W      = 8,
  parameter int LEN    = 629,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic [W-1:0]      data
);
  localparam int              MID  = 1 << (W - 1);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(LEN - 1);

  logic [W-1:0] rom [LEN];

  initial begin
    for (int k = 0; k < LEN; k++) rom[k] = W'(tone_pkg::sine_entry(k, MID));
  end

  always_ff @(posedge clk) begin
    if (rst || clear)  addr <= '0;
    else if (step)     addr <= (addr == LAST) ? '0 : addr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) data <= W'(MID);
    else     data <= rom[addr];
  end
endmodule

// File: rtl/tone_gen.sv
module tone_gen #(
  parameter int CLK_HZ    = 25_000_000,
  parameter int FREQ_W    = 10,
  parameter int SAMPLE_W  = 8,
  parameter int TABLE_LEN = 629
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en_i,
  input  logic [1:0]          wave_i,
  input  logic [FREQ_W-1:0]   freq_i,
  output logic                square_o,
  output logic [SAMPLE_W-1:0] sample_o
);
  import tone_pkg::*;

  localparam int CNT_W     = $clog2(CLK_HZ / 2 + 1);
  localparam int ADDR_W    = $clog2(TABLE_LEN);
  localparam int TRI_STEPS = 2 * ((1 << SAMPLE_W) - 1);
  localparam logic [SAMPLE_W-1:0] MID = SAMPLE_W'(1 << (SAMPLE_W - 1));

  wave_e wave;
  assign wave = wave_e'(wave_i);

  // named internal events for the checker
  logic                tick;
  logic [CNT_W-1:0]    interval;
  logic [CNT_W-1:0]    div_cnt;
  logic [SAMPLE_W-1:0] tri_val;
  logic                tri_up;
  logic [ADDR_W-1:0]   sine_addr;
  logic [SAMPLE_W-1:0] sine_q;
  logic                sq_q;
  logic                step_tri;
  logic                step_sine;

  assign step_tri  = tick && (wave == WAVE_TRI);
  assign step_sine = tick && (wave == WAVE_SINE);

  tone_rate #(
    .CLK_HZ(CLK_HZ), .FREQ_W(FREQ_W), .CNT_W(CNT_W),
    .TRI_STEPS(TRI_STEPS), .SIN_STEPS(TABLE_LEN)
  ) u_rate (
    .clk(clk), .rst(rst), .en(en_i), .wave(wave_i), .freq(freq_i),
    .tick(tick), .interval(interval), .cnt(div_cnt)
  );

  tone_tri #(.W(SAMPLE_W)) u_tri (
    .clk(clk), .rst(rst), .clear(!en_i), .step(step_tri),
    .val(tri_val), .up(tri_up)
  );

  tone_sine #(.W(SAMPLE_W), .LEN(TABLE_LEN), .ADDR_W(ADDR_W)) u_sine (
    .clk(clk), .rst(rst), .clear(!en_i), .step(step_sine),
    .addr(sine_addr), .data(sine_q)
  );

  always_ff @(posedge clk) begin
    if (rst || !en_i)                        sq_q <= 1'b0;
    else if (tick && wave == WAVE_SQUARE)    sq_q <= !sq_q;
  end

  assign square_o = en_i && (wave == WAVE_SQUARE) && sq_q;

  always_comb begin
    if (!en_i) sample_o = MID;
    else begin
      case (wave)
        WAVE_TRI:  sample_o = tri_val;
        WAVE_SINE: sample_o = sine_q;
        default:   sample_o = MID;
      endcase
    end
  end
endmodule

// File: rtl/tone_gen_chk.sv
module tone_gen_chk #(
  parameter int CNT_W    = 24,
  parameter int SAMPLE_W = 8,
  parameter int ADDR_W   = 10,
  parameter int TABLE_LEN = 629
) (
  input logic                clk,
  input logic                rst,
  input logic                en_i,
  input logic [1:0]          wave_i,
  input logic                tick,
  input logic [CNT_W-1:0]    interval,
  input logic [CNT_W-1:0]    div_cnt,
  input logic [SAMPLE_W-1:0] tri_val,
  input logic [ADDR_W-1:0]   sine_addr
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(TABLE_LEN - 1);

  // R7
  idle_restart_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (tri_val == '0 && sine_addr == '0 && div_cnt == '0));

  // R5
  addr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && wave_i == 2'd2 && sine_addr == LAST) |=> sine_addr == '0);

  // R6
  div_reload_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> div_cnt == CNT_W'($past(interval) - 1'b1));

  // R9
  tri_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en_i && !(tick && wave_i == 2'd1)) |=> $stable(tri_val));

  // R3
  tri_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en_i && tick && wave_i == 2'd1) |=>
      (tri_val == SAMPLE_W'($past(tri_val) + 1'b1) ||
       tri_val == SAMPLE_W'($past(tri_val) - 1'b1)));
endmodule

bind tone_gen tone_gen_chk #(
  .CNT_W(CNT_W), .SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W), .TABLE_LEN(TABLE_LEN)
) chk_i (
  .clk(clk), .rst(rst), .en_i(en_i), .wave_i(wave_i), .tick(tick),
  .interval(interval), .div_cnt(div_cnt), .tri_val(tri_val),
  .sine_addr(sine_addr)
);

// File: tb/tone_gen_test.sv
module tone_gen_test;
  localparam int CLK = 100_000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [1:0] wave = 2'd1;
  logic [9:0] freq = 10'd200;
  logic       square_o;
  logic [7:0] sample_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  tone_gen #(.CLK_HZ(CLK)) uut (
    .clk(clk), .rst(rst), .en_i(en), .wave_i(wave), .freq_i(freq),
    .square_o(square_o), .sample_o(sample_o)
  );

  // ---------------- requirement-level reference ----------------
  function automatic int ref_entry(int k);
    real s;
    s = 127.0 * $sin(k * 0.01) + 128.5;
    return int'($floor(s));
  endfunction

  function automatic int ref_step(int f, int w);
    int per_period;
    int r;
    per_period = (w == 1) ? 510 : (w == 2) ? 629 : 2;
    r = CLK / ((f < 1 ? 1 : f) * per_period);
    return (r < 1) ? 1 : r;
  endfunction

  int   m_cnt, m_tri, m_addr, m_q;
  logic m_sq, m_up;

  always @(posedge clk) begin
    m_q <= rst ? 128 : ref_entry(m_addr);
    if (rst || !en) begin
      m_cnt <= 0; m_sq <= 1'b0; m_tri <= 0; m_up <= 1'b1; m_addr <= 0;
    end else if (m_cnt != 0) begin
      m_cnt <= m_cnt - 1;
    end else begin
      m_cnt <= ref_step(int'(freq), int'(wave)) - 1;
      case (wave)
        2'd0: m_sq <= !m_sq;
        2'd1: begin
          if (m_up && m_tri == 255)    begin m_up <= 1'b0; m_tri <= 254; end
          else if (!m_up && m_tri == 0) begin m_up <= 1'b1; m_tri <= 1; end
          else m_tri <= m_up ? m_tri + 1 : m_tri - 1;
        end
        2'd2: m_addr <= (m_addr == 628) ? 0 : m_addr + 1;
        default: ;
      endcase
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150_000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected under 150000", cyc);
      summary();
    end
  end

  // ---------------- stimulus vectors ----------------
  typedef struct packed {
    logic [1:0]  w;
    logic [9:0]  f;
    logic [15:0] n;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{w: 2'd0, f: 10'd50,   n: 16'd2600},
    '{w: 2'd0, f: 10'd440,  n: 16'd500},
    '{w: 2'd1, f: 10'd10,   n: 16'd10000},
    '{w: 2'd1, f: 10'd200,  n: 16'd1100},
    '{w: 2'd2, f: 10'd10,   n: 16'd9600},
    '{w: 2'd2, f: 10'd200,  n: 16'd1300},
    '{w: 2'd3, f: 10'd100,  n: 16'd200},
    '{w: 2'd1, f: 10'd0,    n: 16'd1000},
    '{w: 2'd0, f: 10'd1023, n: 16'd300}
  };

  task automatic restart(logic [1:0] w, logic [9:0] f);
    @(negedge clk); en = 1'b0;
    @(negedge clk); en = 1'b1; wave = w; freq = f;
  endtask

  task automatic after_edges(int j);
    repeat (j) @(posedge clk);
    #2;
  endtask

  initial begin
    // R8: reset state, triangle selected and enabled during reset
    en = 1'b1; wave = 2'd1; freq = 10'd200;
    repeat (3) @(posedge clk);
    #2;
    chk("R8 square", int'(square_o), 0);
    chk("R8 triangle start", int'(sample_o), 0);
    @(negedge clk); wave = 2'd2;
    #2;
    chk("R8 sine mid", int'(sample_o), 128);
    @(negedge clk); wave = 2'd1; rst = 1'b0;
    // R3: interval 1 -> first enabled edge steps 0 to 1
    after_edges(1);
    chk("R3 first step", int'(sample_o), 1);
    after_edges(254);
    chk("R3 peak", int'(sample_o), 255);
    after_edges(1);
    chk("R3 turn down", int'(sample_o), 254);

    // R7: enable low gives midscale at once, then restart from zero
    @(negedge clk); en = 1'b0;
    #2;
    chk("R7 idle sample", int'(sample_o), 128);
    chk("R7 idle square", int'(square_o), 0);
    @(negedge clk); en = 1'b1;
    after_edges(1);
    chk("R7 restart", int'(sample_o), 1);

    // R2: f=50 -> N=1000
    restart(2'd0, 10'd50);
    after_edges(1);
    chk("R2 first high", int'(square_o), 1);
    chk("R2 sample mid", int'(sample_o), 128);
    after_edges(999);
    chk("R2 still high", int'(square_o), 1);
    after_edges(1);
    chk("R2 toggled low", int'(square_o), 0);

    // R4/R5: sine at interval 1; after edge j sample is entry j-1
    restart(2'd2, 10'd200);
    after_edges(1);
    chk("R4 entry 0", int'(sample_o), 128);
    after_edges(157);
    chk("R4 entry 157", int'(sample_o), 255);
    after_edges(471);
    chk("R4 entry 628", int'(sample_o), 128);
    after_edges(1);
    chk("R5 wrap to entry 0", int'(sample_o), 128);
    after_edges(1);
    chk("R5 entry 1 after wrap", int'(sample_o), 129);

    // R1: code 3 is silent
    @(negedge clk); wave = 2'd3;
    #2;
    chk("R1 off sample", int'(sample_o), 128);
    chk("R1 off square", int'(square_o), 0);

    // vector walk against the reference, every cycle (R1 R2 R3 R5 R6 R9)
    restart(2'd0, 10'd50);
    for (int v = 0; v < 9; v++) begin
      if (v != 0) begin
        @(negedge clk); wave = VECS[v].w; freq = VECS[v].f;
      end
      for (int c = 0; c < int'(VECS[v].n); c++) begin
        @(posedge clk);
        #2;
        chk((VECS[v].w == 2'd0) ? "R2 square" : "R9 square",
            int'(square_o), int'(en && wave == 2'd0 && m_sq));
        chk((VECS[v].w == 2'd1) ? "R3 triangle" :
            (VECS[v].w == 2'd2) ? "R5 sine" :
            (VECS[v].w == 2'd3) ? "R1 silent" : "R6 sample",
            int'(sample_o),
            (wave == 2'd1) ? m_tri : (wave == 2'd2) ? m_q : 128);
      end
    end
    summary();
  end
endmodule